// File: doc/BRIEF.md
# Keyboard Controller Host Command Processor

This block is the host-facing register front end of a PC-style keyboard controller. The host sees one byte-wide port pair, and a single address bit chooses between them. A write with the bit high is a command. A write with the bit low is data. The status byte is always visible on a parallel output, so reading it has no side effects.

Some commands act at once. They can push a reply byte toward the keyboard output queue, edit the configuration (mode) byte, or set the self-test flag. Other commands only arm a pending state, which decides what the next data write means. That data write can load the mode byte, inject a byte into the keyboard or aux queue, load the output port, or forward the byte to the aux device. Once that data write is handled, the pending state clears. A data write with nothing pending goes to the keyboard device.

All pushes and forwards leave the block as single-cycle pulses from registers, one cycle after the write. The serial device protocols, the queues and interrupt routing live outside this block.

Top module: `kbc_host_regs`

## Requirements
- R1: After reset, status reads 0x18 when both queue-full inputs are low. The mode byte is 0x03, so both interrupt enables are 1, translation is 0 and command 0x20 replies 0x03. The output port reads 0xCF and no pulse output is high.
- R2: Command 0x20 pushes the current mode byte to the keyboard queue. The push shows as push_vld_o=1 and push_aux_o=0 in the cycle after the write.
- R3: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 produce no pulse of any kind. The next data write is handled according to that command. After it, a further data write goes to the keyboard device.
- R4: A data write after 0x60 loads the mode byte. xlat_o equals mode bit 6. kirq_en_o equals bit 0 AND NOT bit 4. airq_en_o equals bit 1.
- R5: A data write after 0xD2 pushes that byte to the keyboard queue (push_aux_o=0). After 0xD3 the byte goes to the aux queue instead (push_aux_o=1).
- R6: A data write after 0xD1 loads outp_o and pulses outp_vld_o. Command 0xD0 pushes the current output-port value to the keyboard queue.
- R7: A data write after 0xD4 pulses adev_vld_o with the byte on dev_byte_o. With nothing pending, a data write pulses kdev_vld_o with the byte instead.
- R8: Command 0xAA sets status bit 2 and pushes 0x55; the bit stays set until reset. Commands 0xA9 and 0xAB push 0x00. Command 0xC0 pushes 0x80.
- R9: Commands 0xA7 and 0xA8 set and clear mode bit 5. Commands 0xAD and 0xAE set and clear mode bit 4, and kirq_en_o follows in the next cycle.
- R10: Status bit 3 is 1 after a command write and 0 after a data write. Bit 0 is the OR of the two queue-full inputs. Bit 5 is the aux-full input when the keyboard-full input is low. Bit 4 is 1. Bits 1, 6 and 7 are 0.
- R11: Any other command code pulses err_o for one cycle and leaves the mode byte, the pending state and all other outputs unchanged.
- R12: A command that does not arm leaves any pending state intact. An arming command issued while another is pending replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_cmd | input | 1 | Port select: 1 command port, 0 data port |
| wr_data | input | 8 | Written byte |
| kq_full_i | input | 1 | Keyboard output queue holds data |
| aq_full_i | input | 1 | Aux output queue holds data |
| status_o | output | 8 | Status byte |
| push_vld_o | output | 1 | Queue push pulse |
| push_aux_o | output | 1 | Push target: 1 aux queue, 0 keyboard queue |
| push_byte_o | output | 8 | Pushed byte |
| kdev_vld_o | output | 1 | Forward-to-keyboard-device pulse |
| adev_vld_o | output | 1 | Forward-to-aux-device pulse |
| dev_byte_o | output | 8 | Forwarded byte |
| outp_o | output | 8 | Output port register |
| outp_vld_o | output | 1 | Output port written pulse |
| xlat_o | output | 1 | Scan-code translation enable |
| kirq_en_o | output | 1 | Keyboard interrupt enable |
| airq_en_o | output | 1 | Aux interrupt enable |
| err_o | output | 1 | Unknown command pulse |

## Verification
The bench builds the block with its default reset values: mode 0x03 and output port 0xCF. Because the byte is only eight bits wide, it can sweep every one of the 256 command codes from a fresh reset. For each code it checks the error pulse, the reply byte, the mode edits and the two-phase follow-up. It also sweeps all 256 mode values through the load-and-readback path. Directed sequences then cover the queue-full status mapping, re-arming while a command is pending, and a non-arming command issued while one is pending.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int DW = 8;

  // command codes
  localparam logic [DW-1:0] OP_MODE_RD  = 8'h20;
  localparam logic [DW-1:0] OP_MODE_WR  = 8'h60;
  localparam logic [DW-1:0] OP_AUX_OFF  = 8'hA7;
  localparam logic [DW-1:0] OP_AUX_ON   = 8'hA8;
  localparam logic [DW-1:0] OP_AUX_CHK  = 8'hA9;
  localparam logic [DW-1:0] OP_SELF_CHK = 8'hAA;
  localparam logic [DW-1:0] OP_KBD_CHK  = 8'hAB;
  localparam logic [DW-1:0] OP_KBD_OFF  = 8'hAD;
  localparam logic [DW-1:0] OP_KBD_ON   = 8'hAE;
  localparam logic [DW-1:0] OP_INP_RD   = 8'hC0;
  localparam logic [DW-1:0] OP_OUTP_RD  = 8'hD0;
  localparam logic [DW-1:0] OP_OUTP_WR  = 8'hD1;
  localparam logic [DW-1:0] OP_KQ_INJ   = 8'hD2;
  localparam logic [DW-1:0] OP_AQ_INJ   = 8'hD3;
  localparam logic [DW-1:0] OP_ADEV_FWD = 8'hD4;

  // mode bit positions
  localparam int MB_KIRQ = 0;
  localparam int MB_AIRQ = 1;
  localparam int MB_KOFF = 4;
  localparam int MB_AOFF = 5;
  localparam int MB_XLAT = 6;

  // status bit positions
  localparam int SB_OBF  = 0;
  localparam int SB_SELF = 2;
  localparam int SB_CMD  = 3;
  localparam int SB_UNLK = 4;
  localparam int SB_AOBF = 5;

  typedef enum logic [1:0] {
    PS_MODE  = 2'd0,
    PS_OUTP  = 2'd1,
    PS_CONST = 2'd2
  } psrc_e;

  typedef struct packed {
    logic          arm;
    logic          push;
    psrc_e         src;
    logic [DW-1:0] cval;
    logic [DW-1:0] mset;
    logic [DW-1:0] mclr;
    logic          selftest;
    logic          err;
  } cdec_t;
endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
  import kbc_pkg::*;
(
  input  logic [DW-1:0] code_i,
  output cdec_t         dec_o
);
  always_comb begin
    dec_o     = '0;
    dec_o.src = PS_CONST;
    case (code_i)
      OP_MODE_RD: begin
        dec_o.push = 1'b1;
        dec_o.src  = PS_MODE;
      end
      OP_MODE_WR, OP_OUTP_WR, OP_KQ_INJ, OP_AQ_INJ, OP_ADEV_FWD:
        dec_o.arm = 1'b1;
      OP_AUX_OFF: dec_o.mset[MB_AOFF] = 1'b1;
      OP_AUX_ON:  dec_o.mclr[MB_AOFF] = 1'b1;
      OP_KBD_OFF: dec_o.mset[MB_KOFF] = 1'b1;
      OP_KBD_ON:  dec_o.mclr[MB_KOFF] = 1'b1;
      OP_AUX_CHK, OP_KBD_CHK: begin
        dec_o.push = 1'b1;
        dec_o.cval = 8'h00;
      end
      OP_SELF_CHK: begin
        dec_o.push     = 1'b1;
        dec_o.cval     = 8'h55;
        dec_o.selftest = 1'b1;
      end
      OP_INP_RD: begin
        dec_o.push = 1'b1;
        dec_o.cval = 8'h80;
      end
      OP_OUTP_RD: begin
        dec_o.push = 1'b1;
        dec_o.src  = PS_OUTP;
      end
      default: dec_o.err = 1'b1;
    endcase
  end
endmodule

// File: rtl/kbc_state.sv
module kbc_state
  import kbc_pkg::*;
#(
  parameter logic [DW-1:0] MODE_RST = 8'h03,
  parameter logic [DW-1:0] OUTP_RST = 8'hCF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic          dat_wr,
  input  logic [DW-1:0] wr_data,
  input  logic          dec_arm,
  input  logic          dec_self,
  input  logic [DW-1:0] dec_mset,
  input  logic [DW-1:0] dec_mclr,
  output logic [DW-1:0] mode_q,
  output logic [DW-1:0] pend_q,
  output logic          self_q,
  output logic          lastcmd_q,
  output logic [DW-1:0] outp_q,
  output logic          d_kdev,
  output logic          d_adev,
  output logic          d_kq,
  output logic          d_aq,
  output logic          d_outp
);
  logic          d_mode;
  logic [DW-1:0] mode_d, pend_d;
  logic          mode_en, pend_en, self_en, lc_en;

  always_comb begin
    d_kdev  = dat_wr && (pend_q == '0);
    d_mode  = dat_wr && (pend_q == OP_MODE_WR);
    d_outp  = dat_wr && (pend_q == OP_OUTP_WR);
    d_kq    = dat_wr && (pend_q == OP_KQ_INJ);
    d_aq    = dat_wr && (pend_q == OP_AQ_INJ);
    d_adev  = dat_wr && (pend_q == OP_ADEV_FWD);

    mode_en = cmd_wr || d_mode;
    mode_d  = cmd_wr ? ((mode_q & ~dec_mclr) | dec_mset) : wr_data;

    pend_en = (cmd_wr && dec_arm) || dat_wr;
    pend_d  = cmd_wr ? wr_data : '0;

    self_en = cmd_wr && dec_self;
    lc_en   = cmd_wr || dat_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_RST;
      pend_q    <= '0;
      self_q    <= 1'b0;
      lastcmd_q <= 1'b1;
      outp_q    <= OUTP_RST;
    end else begin
      if (mode_en) mode_q    <= mode_d;
      if (pend_en) pend_q    <= pend_d;
      if (self_en) self_q    <= 1'b1;
      if (lc_en)   lastcmd_q <= cmd_wr;
      if (d_outp)  outp_q    <= wr_data;
    end
  end
endmodule

// File: rtl/kbc_egress.sv
module kbc_egress
  import kbc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic          dec_push,
  input  psrc_e         dec_src,
  input  logic [DW-1:0] dec_cval,
  input  logic          dec_err,
  input  logic          d_kdev,
  input  logic          d_adev,
  input  logic          d_kq,
  input  logic          d_aq,
  input  logic          d_outp,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] mode_q,
  input  logic [DW-1:0] outp_q,
  output logic          push_vld_q,
  output logic          push_aux_q,
  output logic [DW-1:0] push_byte_q,
  output logic          kdev_vld_q,
  output logic          adev_vld_q,
  output logic [DW-1:0] dev_byte_q,
  output logic          outp_vld_q,
  output logic          err_q
);
  logic          push_d, dev_en;
  logic [DW-1:0] byte_d;

  always_comb begin
    push_d = (cmd_wr && dec_push) || d_kq || d_aq;
    dev_en = d_kdev || d_adev;
    byte_d = wr_data;
    if (cmd_wr) begin
      case (dec_src)
        PS_MODE: byte_d = mode_q;
        PS_OUTP: byte_d = outp_q;
        default: byte_d = dec_cval;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push_vld_q  <= 1'b0;
      push_aux_q  <= 1'b0;
      push_byte_q <= '0;
      kdev_vld_q  <= 1'b0;
      adev_vld_q  <= 1'b0;
      dev_byte_q  <= '0;
      outp_vld_q  <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      push_vld_q <= push_d;
      kdev_vld_q <= d_kdev;
      adev_vld_q <= d_adev;
      outp_vld_q <= d_outp;
      err_q      <= cmd_wr && dec_err;
      if (push_d) begin
        push_aux_q  <= d_aq;
        push_byte_q <= byte_d;
      end
      if (dev_en) dev_byte_q <= wr_data;
    end
  end
endmodule

// File: rtl/kbc_host_regs.sv
module kbc_host_regs
  import kbc_pkg::*;
#(
  parameter logic [7:0] MODE_RST = 8'h03,
  parameter logic [7:0] OUTP_RST = 8'hCF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_cmd,
  input  logic [7:0] wr_data,
  input  logic       kq_full_i,
  input  logic       aq_full_i,
  output logic [7:0] status_o,
  output logic       push_vld_o,
  output logic       push_aux_o,
  output logic [7:0] push_byte_o,
  output logic       kdev_vld_o,
  output logic       adev_vld_o,
  output logic [7:0] dev_byte_o,
  output logic [7:0] outp_o,
  output logic       outp_vld_o,
  output logic       xlat_o,
  output logic       kirq_en_o,
  output logic       airq_en_o,
  output logic       err_o
);
  cdec_t         dec;
  logic          cmd_wr, dat_wr;
  logic [DW-1:0] mode_q, pend_q;
  logic          self_q, lastcmd_q;
  logic          d_kdev, d_adev, d_kq, d_aq, d_outp;

  assign cmd_wr = wr_en && wr_cmd;
  assign dat_wr = wr_en && !wr_cmd;

  kbc_cmd_decode u_dec (
    .code_i (wr_data),
    .dec_o  (dec)
  );

  kbc_state #(.MODE_RST(MODE_RST), .OUTP_RST(OUTP_RST)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .dat_wr    (dat_wr),
    .wr_data   (wr_data),
    .dec_arm   (dec.arm),
    .dec_self  (dec.selftest),
    .dec_mset  (dec.mset),
    .dec_mclr  (dec.mclr),
    .mode_q    (mode_q),
    .pend_q    (pend_q),
    .self_q    (self_q),
    .lastcmd_q (lastcmd_q),
    .outp_q    (outp_o),
    .d_kdev    (d_kdev),
    .d_adev    (d_adev),
    .d_kq      (d_kq),
    .d_aq      (d_aq),
    .d_outp    (d_outp)
  );

  kbc_egress u_egr (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wr      (cmd_wr),
    .dec_push    (dec.push),
    .dec_src     (dec.src),
    .dec_cval    (dec.cval),
    .dec_err     (dec.err),
    .d_kdev      (d_kdev),
    .d_adev      (d_adev),
    .d_kq        (d_kq),
    .d_aq        (d_aq),
    .d_outp      (d_outp),
    .wr_data     (wr_data),
    .mode_q      (mode_q),
    .outp_q      (outp_o),
    .push_vld_q  (push_vld_o),
    .push_aux_q  (push_aux_o),
    .push_byte_q (push_byte_o),
    .kdev_vld_q  (kdev_vld_o),
    .adev_vld_q  (adev_vld_o),
    .dev_byte_q  (dev_byte_o),
    .outp_vld_q  (outp_vld_o),
    .err_q       (err_o)
  );

  always_comb begin
    status_o          = '0;
    status_o[SB_OBF]  = kq_full_i || aq_full_i;
    status_o[SB_SELF] = self_q;
    status_o[SB_CMD]  = lastcmd_q;
    status_o[SB_UNLK] = 1'b1;
    status_o[SB_AOBF] = aq_full_i && !kq_full_i;
  end

  assign xlat_o    = mode_q[MB_XLAT];
  assign kirq_en_o = mode_q[MB_KIRQ] && !mode_q[MB_KOFF];
  assign airq_en_o = mode_q[MB_AIRQ];
endmodule

// File: rtl/kbc_host_regs_chk.sv
module kbc_host_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_cmd,
  input logic [7:0] wr_data,
  input logic       stat_cmd,
  input logic       stat_self,
  input logic       push_vld,
  input logic       kdev_vld,
  input logic       adev_vld,
  input logic       outp_vld,
  input logic       err,
  input logic       kirq_en,
  input logic [7:0] pend
);
  a_r10_cmd_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_cmd) |=> stat_cmd);

  a_r10_data_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_cmd) |=> !stat_cmd);

  a_r3_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_cmd) |=> (pend == 8'h00));

  a_r12_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push_vld, kdev_vld, adev_vld, outp_vld, err}));

  a_r8_self_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stat_self |=> stat_self);

  a_r9_kbd_off: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_cmd && wr_data == 8'hAD) |=> !kirq_en);

  a_r11_err_keeps_pend: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $stable(pend));
endmodule

bind kbc_host_regs kbc_host_regs_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_cmd    (wr_cmd),
  .wr_data   (wr_data),
  .stat_cmd  (status_o[3]),
  .stat_self (status_o[2]),
  .push_vld  (push_vld_o),
  .kdev_vld  (kdev_vld_o),
  .adev_vld  (adev_vld_o),
  .outp_vld  (outp_vld_o),
  .err       (err_o),
  .kirq_en   (kirq_en_o),
  .pend      (pend_q)
);

// File: tb/kbc_host_regs_tb.sv
module kbc_host_regs_tb;
  logic       clk, rst_n, wr_en, wr_cmd, kq_full_i, aq_full_i;
  logic [7:0] wr_data;
  logic [7:0] status_o, push_byte_o, dev_byte_o, outp_o;
  logic       push_vld_o, push_aux_o, kdev_vld_o, adev_vld_o, outp_vld_o;
  logic       xlat_o, kirq_en_o, airq_en_o, err_o;
  int         n_chk, n_fail, cyc;
  bit         done;

  kbc_host_regs u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd), .wr_data(wr_data),
    .kq_full_i(kq_full_i), .aq_full_i(aq_full_i), .status_o(status_o),
    .push_vld_o(push_vld_o), .push_aux_o(push_aux_o), .push_byte_o(push_byte_o),
    .kdev_vld_o(kdev_vld_o), .adev_vld_o(adev_vld_o), .dev_byte_o(dev_byte_o),
    .outp_o(outp_o), .outp_vld_o(outp_vld_o), .xlat_o(xlat_o),
    .kirq_en_o(kirq_en_o), .airq_en_o(airq_en_o), .err_o(err_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge with the results visible
  task automatic wr(input logic c, input logic [7:0] d);
    wr_en = 1'b1; wr_cmd = c; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic hw_reset();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [4:0] pulses();
    return {push_vld_o, kdev_vld_o, adev_vld_o, outp_vld_o, err_o};
  endfunction

  function automatic bit known(input logic [7:0] c);
    case (c)
      8'h20, 8'h60, 8'hA7, 8'hA8, 8'hA9, 8'hAA, 8'hAB, 8'hAD, 8'hAE,
      8'hC0, 8'hD0, 8'hD1, 8'hD2, 8'hD3, 8'hD4: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // reply from the reset state: {push, byte}
  function automatic logic [8:0] reply(input logic [7:0] c);
    case (c)
      8'h20: return {1'b1, 8'h03};
      8'hAA: return {1'b1, 8'h55};
      8'hA9, 8'hAB: return {1'b1, 8'h00};
      8'hC0: return {1'b1, 8'h80};
      8'hD0: return {1'b1, 8'hCF};
      default: return 9'h000;
    endcase
  endfunction

  function automatic logic [7:0] mode_after(input logic [7:0] c);
    case (c)
      8'hA7: return 8'h23;
      8'hAD: return 8'h13;
      default: return 8'h03;
    endcase
  endfunction

  initial begin
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog act=%0d exp<150000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    logic [8:0] rp;
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; wr_cmd = 1'b0; wr_data = 8'h00;
    kq_full_i = 1'b0; aq_full_i = 1'b0;
    @(negedge clk);
    hw_reset();

    // R1 reset state
    chk("R1 status", status_o, 8'h18);
    chk("R1 pulses", {3'b0, pulses()}, 8'h00);
    chk("R1 irq/xlat", {5'b0, xlat_o, kirq_en_o, airq_en_o}, 8'h03);
    chk("R1 outport", outp_o, 8'hCF);
    wr(1'b1, 8'h20);
    chk("R1 mode readback", push_byte_o, 8'h03);

    // R10 status mapping over queue-full inputs
    for (int i = 0; i < 4; i++) begin
      kq_full_i = i[0]; aq_full_i = i[1];
      #1;
      chk("R10 status", status_o,
          8'h18 | {2'b0, i[1] & ~i[0], 4'b0, i[0] | i[1]});
    end
    kq_full_i = 1'b0; aq_full_i = 1'b0;

    // sweep every command code from reset (R2 R3 R5 R6 R7 R8 R9 R11)
    for (int c = 0; c < 256; c++) begin
      hw_reset();
      wr(1'b1, c[7:0]);
      rp = reply(c[7:0]);
      chk("R11 err", {7'b0, err_o}, {7'b0, ~known(c[7:0])});
      chk("R2 R8 push", {7'b0, push_vld_o}, {7'b0, rp[8]});
      if (rp[8]) begin
        chk("R2 R8 R6 byte", push_byte_o, rp[7:0]);
        chk("R2 aux sel", {7'b0, push_aux_o}, 8'h00);
      end
      chk("R10 cmd flag", {7'b0, status_o[3]}, 8'h01);
      if (c == 8'hAA) chk("R8 selftest bit", {7'b0, status_o[2]}, 8'h01);
      if (c == 8'hAD) chk("R9 kirq off", {7'b0, kirq_en_o}, 8'h00);
      case (c)
        8'h60, 8'hD1, 8'hD2, 8'hD3, 8'hD4: begin
          chk("R3 no pulse on arm", {3'b0, pulses()}, 8'h00);
          wr(1'b0, 8'h4D);
          chk("R10 data flag", {7'b0, status_o[3]}, 8'h00);
          case (c)
            8'h60: chk("R4 mode load", {5'b0, xlat_o, kirq_en_o, airq_en_o}, 8'h06);
            8'hD1: chk("R6 outport wr", {outp_o[7:1], outp_vld_o}, {7'h26, 1'b1});
            8'hD2: chk("R5 kq inj", {push_byte_o[7:1], push_vld_o ^ push_aux_o}, {7'h26, 1'b1});
            8'hD3: chk("R5 aq inj", {push_byte_o[7:1], push_vld_o & push_aux_o}, {7'h26, 1'b1});
            default: chk("R7 aux dev fwd", {dev_byte_o[7:1], adev_vld_o & ~kdev_vld_o}, {7'h26, 1'b1});
          endcase
          wr(1'b0, 8'h11);
          chk("R3 pend cleared", {dev_byte_o[7:1], kdev_vld_o}, {7'h08, 1'b1});
        end
        default: begin
          wr(1'b1, 8'h20);
          chk("R9 R11 mode kept", push_byte_o, mode_after(c[7:0]));
          wr(1'b0, 8'h3C);
          chk("R7 R11 kdev fwd", {dev_byte_o[7:1], kdev_vld_o}, {7'h1E, 1'b1});
        end
      endcase
    end

    // R4 sweep of all mode values
    hw_reset();
    for (int v = 0; v < 256; v++) begin
      logic [7:0] m;
      m = v[7:0];
      wr(1'b1, 8'h60);
      wr(1'b0, m);
      chk("R4 xlat/irq", {5'b0, xlat_o, kirq_en_o, airq_en_o},
          {5'b0, m[6], m[0] & ~m[4], m[1]});
      wr(1'b1, 8'h20);
      chk("R4 R2 readback", push_byte_o, m);
    end

    // R9 enable/disable round trip and aux bit
    hw_reset();
    wr(1'b1, 8'hAD); wr(1'b1, 8'hAE);
    chk("R9 kirq back on", {7'b0, kirq_en_o}, 8'h01);
    wr(1'b1, 8'hA7); wr(1'b1, 8'hA8); wr(1'b1, 8'h20);
    chk("R9 aux bit cleared", push_byte_o, 8'h03);

    // R6 output port readback after write
    wr(1'b1, 8'hD1); wr(1'b0, 8'h5A); wr(1'b1, 8'hD0);
    chk("R6 outport readback", push_byte_o, 8'h5A);

    // R12 non-arming command keeps pending; re-arm replaces it
    wr(1'b1, 8'hD2); wr(1'b1, 8'hAA); wr(1'b0, 8'h77);
    chk("R12 pending survives", {push_byte_o, push_vld_o & ~push_aux_o} >> 1, 8'h77);
    chk("R12 pending survives vld", {7'b0, push_vld_o & ~push_aux_o}, 8'h01);
    wr(1'b1, 8'hD2); wr(1'b1, 8'hD3); wr(1'b0, 8'h66);
    chk("R12 re-arm aux", {7'b0, push_vld_o & push_aux_o}, 8'h01);
    chk("R12 re-arm byte", push_byte_o, 8'h66);
    wr(1'b1, 8'hD4); wr(1'b1, 8'h00); wr(1'b0, 8'h99);
    chk("R11 R12 err keeps pending", {7'b0, adev_vld_o}, 8'h01);
    chk("R8 selftest sticky", {7'b0, status_o[2]}, 8'h01);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule